// File: doc/BRIEF.md
# Parallel SAR Converter Host Sequencer

This block sits on the host side of an external successive-approximation converter that has a parallel data bus. The converter is driven through an active-low chip select, a read/convert select line, a reset line and a byte-select line, and it answers with an active-low end-of-conversion flag. Each conversion uses three falling edges of chip select, and each edge has its own meaning. The first edge, with read/convert low, starts acquisition. The second edge starts the conversion, and the level of read/convert at that edge picks the power state the converter enters afterwards. The third edge, with read/convert high, reads the result.

The user pulses `start_i` and, in the same cycle, gives the power mode wanted after the conversion on `shut_req_i`. The block returns a 16-bit straight-binary code together with a one-cycle strobe. It records whether the converter was last left in shutdown. When it was, the block stretches the first acquisition to the reference settling time and runs one throwaway conversion before the conversion that counts. A parameter chooses the bus width: either a full 16-bit bus, or an 8-bit bus read as two bytes. Every delay is a parameter counted in system clock cycles.

Top module: `sar_host_seq`

## Requirements
- R1: While `rst_n` is low, and for `RST_CYC` cycles after it rises, `adc_reset_o` is high and chip select is high. After that the block is idle: `busy_o` low, `valid_o` low, `err_o` low, `result_o` zero.
- R2: The first chip-select falling edge of every conversion has read/convert low. The block never makes a chip-select falling edge that the converter would ignore or find out of sequence.
- R3: At the second chip-select falling edge, read/convert equals the mode latched from `shut_req_i` at start (1 = shutdown, 0 = standby), except in a throwaway conversion, where it is 0. Read/convert does not change while chip select stays low.
- R4: The third chip-select falling edge has read/convert high. Data is sampled `DOUT_CYC` cycles after chip select falls, and chip select then returns high.
- R5: With `BYTE_BUS`=1, the byte read while `adc_hben_o` is 0 becomes result bits 7:0, and the byte read while `adc_hben_o` is 1 becomes bits 15:8. The code is passed through unchanged as straight binary.
- R6: When the converter is in shutdown (after power-up, after a shutdown-mode conversion, or after a timeout), a start produces two conversions. The first has an acquisition of `WAKE_CYC` cycles and is thrown away, and its result is never reported. The second has a normal acquisition, and its code is the one reported.
- R7: After a standby-mode conversion, a start produces exactly one conversion with an acquisition of `ACQ_CYC` cycles.
- R8: If end-of-conversion does not fall within `EOC_TMO` cycles of the second edge, chip select returns high and `err_o` is set. No strobe is produced, and the next start is treated as coming from shutdown. `err_o` is cleared when the next start is accepted.
- R9: A start request while `busy_o` is high is ignored: it produces no extra conversion and no extra strobe. Chip select is high whenever the block is idle.
- R10: `valid_o` is high for exactly one cycle per reported result. `result_o` changes only in the cycle in which `valid_o` rises.
- R11: `adc_reset_o` is only ever high while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion |
| shut_req_i | input | 1 | Power mode after the conversion: 1 shutdown, 0 standby |
| busy_o | output | 1 | Sequence in progress |
| valid_o | output | 1 | One-cycle strobe for `result_o` |
| result_o | output | 16 | Last reported straight-binary code |
| err_o | output | 1 | End-of-conversion timeout seen |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_rc_o | output | 1 | Converter read/convert select |
| adc_hben_o | output | 1 | Byte select: 0 low byte, 1 high byte |
| adc_reset_o | output | 1 | Converter reset pulse |
| adc_eoc_n_i | input | 1 | End-of-conversion flag, active low |
| adc_data_i | input | 8 or 16 | Converter data bus |

## Verification
A wrong shutdown flag shows at the ports within a single transaction. The number of second chip-select edges is off by one, or the first acquisition has the wrong length. Both show up before the strobe, because the converter model logs every chip-select edge and every acquisition length. A swapped byte or a mis-sequenced read/convert level gives a wrong code at the strobe or a logged out-of-order edge. A broken timeout path either hangs with no `err_o`, or strobes a result that should never appear.

// File: rtl/sar_host_seq.sv
module sar_host_seq #(
  parameter int BYTE_BUS = 0,
  parameter int RST_CYC  = 10,
  parameter int GAP_CYC  = 2,
  parameter int ACQ_CYC  = 150,
  parameter int WAKE_CYC = 1000000,
  parameter int DOUT_CYC = 4,
  parameter int EOC_TMO  = 600,
  localparam int DW = (BYTE_BUS != 0) ? 8 : 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          shut_req_i,
  output logic          busy_o,
  output logic          valid_o,
  output logic [15:0]   result_o,
  output logic          err_o,
  output logic          adc_cs_n_o,
  output logic          adc_rc_o,
  output logic          adc_hben_o,
  output logic          adc_reset_o,
  input  logic          adc_eoc_n_i,
  input  logic [DW-1:0] adc_data_i
);
  localparam int M1 = (WAKE_CYC > EOC_TMO) ? WAKE_CYC : EOC_TMO;
  localparam int M2 = (ACQ_CYC > RST_CYC) ? ACQ_CYC : RST_CYC;
  localparam int M3 = (GAP_CYC > DOUT_CYC) ? GAP_CYC : DOUT_CYC;
  localparam int M4 = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M4 > M3) ? M4 : M3;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [3:0] {
    S_RST, S_IDLE, S_ASET, S_ACQ, S_CSET, S_CONV, S_RSET, S_READ, S_DONE
  } st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic          shut_q, dummy_q, mode_q, hi_q, valid_q, err_q, eoc_q;
  logic [15:0]   res_q, out_q;
  logic [15:0]   din;
  int            lim;
  logic          last;

  assign din = 16'(adc_data_i);

  always_comb begin
    case (st)
      S_RST:   lim = RST_CYC;
      S_ACQ:   lim = dummy_q ? WAKE_CYC : ACQ_CYC;
      S_CONV:  lim = EOC_TMO;
      S_READ:  lim = DOUT_CYC;
      default: lim = GAP_CYC;
    endcase
  end

  assign last = (cnt == CW'(lim - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_RST;
      cnt     <= '0;
      shut_q  <= 1'b1;
      dummy_q <= 1'b0;
      mode_q  <= 1'b0;
      hi_q    <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      eoc_q   <= 1'b1;
      res_q   <= '0;
      out_q   <= '0;
    end else begin
      eoc_q   <= adc_eoc_n_i;
      valid_q <= 1'b0;
      cnt     <= cnt + 1'b1;
      case (st)
        S_RST: if (last) begin st <= S_IDLE; cnt <= '0; end
        S_IDLE: begin
          cnt <= '0;
          if (start_i) begin
            mode_q  <= shut_req_i;
            dummy_q <= shut_q;
            shut_q  <= 1'b0;
            err_q   <= 1'b0;
            st      <= S_ASET;
          end
        end
        S_ASET: if (last) begin st <= S_ACQ;  cnt <= '0; end
        S_ACQ:  if (last) begin st <= S_CSET; cnt <= '0; end
        S_CSET: if (last) begin st <= S_CONV; cnt <= '0; end
        S_CONV: begin
          if (eoc_q && !adc_eoc_n_i) begin
            st  <= S_RSET;
            cnt <= '0;
          end else if (last) begin
            err_q   <= 1'b1;
            shut_q  <= 1'b1;
            dummy_q <= 1'b0;
            st      <= S_IDLE;
            cnt     <= '0;
          end
        end
        S_RSET: if (last) begin st <= S_READ; cnt <= '0; hi_q <= 1'b0; end
        S_READ: begin
          if (last) begin
            cnt <= '0;
            if (BYTE_BUS != 0 && !hi_q) begin
              res_q[7:0] <= din[7:0];
              hi_q       <= 1'b1;
            end else begin
              if (BYTE_BUS != 0) res_q[15:8] <= din[7:0];
              else               res_q       <= din;
              st <= S_DONE;
            end
          end
        end
        S_DONE: begin
          cnt <= '0;
          if (dummy_q) begin
            dummy_q <= 1'b0;
            st      <= S_ASET;
          end else begin
            valid_q <= 1'b1;
            out_q   <= res_q;
            shut_q  <= mode_q;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign adc_cs_n_o  = !(st == S_ACQ || st == S_CONV || st == S_READ);
  assign adc_rc_o    = (st == S_ASET || st == S_ACQ) ? 1'b0 :
                       (st == S_CSET || st == S_CONV) ? (!dummy_q && mode_q) : 1'b1;
  assign adc_hben_o  = (st == S_READ) && hi_q && (BYTE_BUS != 0);
  assign adc_reset_o = (st == S_RST);
  assign busy_o      = (st != S_IDLE);
  assign valid_o     = valid_q;
  assign result_o    = out_q;
  assign err_o       = err_q;

  a_r3_rc_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n_o && $past(!adc_cs_n_o)) |-> $stable(adc_rc_o));
  a_r4_hben_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    adc_hben_o |-> (!adc_cs_n_o && adc_rc_o));
  a_r8_err_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o);
  a_r9_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> adc_cs_n_o);
  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o));
  a_r11_reset_cs: assert property (@(posedge clk) disable iff (!rst_n)
    adc_reset_o |-> adc_cs_n_o);
endmodule

// File: tb/sar_host_seq_tb.sv
`timescale 1ns/1ps
module sar_host_seq_tb;
  localparam int RSTC = 3, GAP = 2, ACQ = 6, WAKE = 50, DOUT = 3, TMO = 40;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, shut_req, busy, valid, err, cs_n, rc, hben, adc_reset;
  logic [15:0] result;
  logic eoc_n = 1'b1;
  logic [7:0] adc_data;

  sar_host_seq #(.BYTE_BUS(1), .RST_CYC(RSTC), .GAP_CYC(GAP), .ACQ_CYC(ACQ),
                 .WAKE_CYC(WAKE), .DOUT_CYC(DOUT), .EOC_TMO(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .shut_req_i(shut_req),
    .busy_o(busy), .valid_o(valid), .result_o(result), .err_o(err),
    .adc_cs_n_o(cs_n), .adc_rc_o(rc), .adc_hben_o(hben), .adc_reset_o(adc_reset),
    .adc_eoc_n_i(eoc_n), .adc_data_i(adc_data));

  // converter model
  int cyc = 0, phase = 0, timer = 0, convs = 0, acq_start = 0, acq_prev = 0, acq_last = 0, bad_edges = 0;
  logic prev_cs = 1'b1, mode_prev = 1'b0, mode_last = 1'b0;
  logic [15:0] sample = 16'h0, base_val = 16'h0;
  bit stall = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    prev_cs <= cs_n;
    if (!rst_n || adc_reset) begin
      phase <= 0;
      eoc_n <= 1'b1;
    end else if (prev_cs && !cs_n) begin
      if ((phase == 0 || phase == 3) && !rc) begin
        phase <= 1; eoc_n <= 1'b1; acq_start <= cyc;
      end else if (phase == 1) begin
        phase <= 2; timer <= 12; convs <= convs + 1;
        acq_prev <= acq_last; acq_last <= cyc - acq_start;
        mode_prev <= mode_last; mode_last <= rc;
      end else if (phase == 3 && rc) phase <= 4;
      else bad_edges <= bad_edges + 1;
    end else if (!prev_cs && cs_n && phase == 4) phase <= 0;
    else if (phase == 2) begin
      if (timer != 0) timer <= timer - 1;
      else if (!stall) begin
        eoc_n <= 1'b0; phase <= 3; sample <= base_val + 16'(convs);
      end
    end
  end

  assign adc_data = (phase == 4 && !cs_n) ? (hben ? sample[15:8] : sample[7:0]) : 8'h00;

  // monitor
  int checks = 0, errors = 0, vcyc = 0, vpul = 0, rst_hi = 0, rst_bad = 0, ncyc = 0;
  logic vprev = 1'b0;
  always @(negedge clk) begin
    ncyc <= ncyc + 1;
    vprev <= valid;
    if (valid) vcyc <= vcyc + 1;
    if (valid && !vprev) vpul <= vpul + 1;
    if (rst_n && adc_reset) begin
      if (cs_n) rst_hi <= rst_hi + 1; else rst_bad <= rst_bad + 1;
    end
    if (ncyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  bit exp_shut = 1'b1;

  task automatic run_txn(input logic [15:0] target, input bit sh, input bit extra);
    int cb = convs, vcb = vcyc, vpb = vpul, w = 0;
    bit dum = exp_shut;
    base_val = target - 16'(cb + 1 + (dum ? 1 : 0));
    shut_req = sh; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extra) begin
      repeat (18) @(negedge clk);
      check(busy == 1'b1, "R9", "busy at second start", busy, 1);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!valid && !err && w < 3000) begin @(negedge clk); w++; end
    check(valid == 1'b1, "R10", "strobe seen", valid, 1);
    check(result == target, "R5", "result code", result, target);
    check(convs - cb == 1 + (dum ? 1 : 0), dum ? "R6" : "R7", "conversion count", convs - cb, 1 + (dum ? 1 : 0));
    check(acq_last == ACQ + GAP, "R7", "normal acquisition", acq_last, ACQ + GAP);
    if (dum) begin
      check(acq_prev == WAKE + GAP, "R6", "wake acquisition", acq_prev, WAKE + GAP);
      check(mode_prev == 1'b0, "R6", "dummy mode standby", mode_prev, 0);
    end
    check(mode_last == sh, "R3", "mode at convert edge", mode_last, sh);
    check(err == 1'b0, "R8", "error cleared", err, 0);
    @(negedge clk);
    check(valid == 1'b0, "R10", "strobe length", valid, 0);
    repeat (3) @(negedge clk);
    check(vcyc - vcb == 1 && vpul - vpb == 1, "R9", "single strobe", vcyc - vcb, 1);
    check(busy == 1'b0 && cs_n == 1'b1, "R9", "idle after result", busy, 0);
    exp_shut = sh;
  endtask

  task automatic run_fault(input bit sh);
    int cb = convs, vpb = vpul, w = 0;
    stall = 1'b1; shut_req = sh; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!err && w < 3000) begin @(negedge clk); w++; end
    check(err == 1'b1, "R8", "timeout flag", err, 1);
    check(cs_n == 1'b1 && busy == 1'b0, "R8", "released after timeout", cs_n, 1);
    check(convs - cb == 1, "R8", "one conversion started", convs - cb, 1);
    repeat (5) @(negedge clk);
    check(vpul == vpb, "R8", "no strobe", vpul - vpb, 0);
    stall = 1'b0;
    repeat (30) @(negedge clk);
    exp_shut = 1'b1;
  endtask

  function automatic logic [15:0] pick(input int i);
    case (i)
      0: return 16'h0000; 1: return 16'hFFFF; 2: return 16'h00FF; 3: return 16'hFF00;
      4: return 16'h8000; 5: return 16'h0001; 6: return 16'hAAAA; 7: return 16'h5555;
      default: return 16'(i * 16'h2F1B + 16'h0437);
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; start = 1'b0; shut_req = 1'b0;
    repeat (4) @(negedge clk);
    check(cs_n == 1'b1 && valid == 1'b0 && err == 1'b0, "R1", "reset outputs", {cs_n, valid, err}, 3'b100);
    check(result == 16'h0, "R1", "reset result", result, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(rst_hi == RSTC, "R1", "reset pulse length", rst_hi, RSTC);
    check(rst_bad == 0, "R11", "reset with cs low", rst_bad, 0);
    check(busy == 1'b0, "R1", "idle after reset", busy, 0);
    for (int i = 0; i < 40; i++) begin
      if (i == 13 || i == 27) run_fault(i[0]);
      else run_txn(pick(i), (i % 3) == 1, (i % 5) == 2);
    end
    check(bad_edges == 0, "R2", "out-of-sequence edges", bad_edges, 0);
    check(bad_edges == 0 && convs > 40, "R4", "reads completed", convs, 41);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule